// File: doc/BRIEF.md
# PCM Frame Sync Timing Generator

This block produces the bit and time-slot timing for a multi-channel PCM serial port. Everything runs on the bit clock `clk`. In register mode the block watches one shared frame-sync input. The rising transition of that input marks a frame, so a one-clock pulse and a half-duty square wave act the same way. The transmit frame start and the receive frame start each lag that event by their own programmed delay of 0 to 7 clocks. From its start point each direction runs a bit index (0 to 7) and a slot index. Each direction also has a slot-enable, and a one-cycle strobe marks the first bit of each frame.

In strap mode the shared sync is not used. Each channel has its own one-clock sync pin. A channel's eight-bit window opens in the slot that follows the falling edge of its pulse. A per-channel enable and bit index show that window.

In register mode the block also watches the sync period. A sync that comes before a full frame has passed sets a sticky error flag and restarts the counters. If two frame periods go by with no sync, the block reports loss of sync and holds the slot-enables low.

Top module: `pcm_frame_timer`

## Requirements
- R1: While reset is held, and until the first sync, `tx_slot_en`, `rx_slot_en`, `tx_frame_start`, `rx_frame_start`, `ch_en` and `frame_err` are 0 and `sync_lost` is 1.
- R2: In register mode, a sync event is a clock where `fsync` is sampled 1 after it was sampled 0. If `fsync` stays high, no further events occur, so a pulse and a square wave give the same timing.
- R3: Let a sync event be sampled at edge t. `tx_frame_start` is then high in exactly the cycle after edge t+D, where D is `cfg_tx_shift` (0..7). In that cycle `tx_slot_en`=1, `tx_slot`=0 and `tx_bit`=0.
- R4: The receive side follows the same rule with its own delay `cfg_rx_shift`, set independently of the transmit delay.
- R5: While a direction is enabled, its bit index rises by one each clock and wraps from 7 to 0. At each wrap the slot index rises by one. After FRAME_LEN = NUM_SLOTS*8 clocks the position returns to slot 0, bit 0.
- R6: A delay written with `cfg_we` is used from the next sync event on. A frame that is already running keeps its old start point.
- R7: A sync event that comes fewer than FRAME_LEN clocks after the previous one sets `frame_err`. The flag stays set until reset, and the counters restart from the new event. A period of exactly FRAME_LEN never sets the flag.
- R8: If 2*FRAME_LEN clocks pass after a sync event with no new event, `sync_lost` rises in the cycle after edge t+2*FRAME_LEN, and both slot-enables are low whenever `sync_lost` is high.
- R9: In strap mode, let channel i's pin be sampled high at edge t and low at edge t+1. Then `ch_en[i]` is high for the eight cycles after edges t+1..t+8, and `ch_bit[3*i+2:3*i]` counts 0..7 across those cycles. Each channel is independent.
- R10: In strap mode `fsync` has no effect and both slot-enables stay low. In register mode `ch_fsync` has no effect and `ch_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 1 | 1 = per-channel sync mode, 0 = register mode (static) |
| fsync | input | 1 | Shared frame sync (register mode) |
| ch_fsync | input | NUM_CH | Per-channel one-clock syncs (strap mode) |
| cfg_we | input | 1 | Write strobe for the delay fields |
| cfg_tx_shift | input | 3 | Transmit start delay in clocks |
| cfg_rx_shift | input | 3 | Receive start delay in clocks |
| tx_frame_start | output | 1 | Transmit frame first-bit strobe |
| tx_slot_en | output | 1 | Transmit timing active |
| tx_slot | output | SLOT_W | Transmit slot index |
| tx_bit | output | 3 | Transmit bit index |
| rx_frame_start | output | 1 | Receive frame first-bit strobe |
| rx_slot_en | output | 1 | Receive timing active |
| rx_slot | output | SLOT_W | Receive slot index |
| rx_bit | output | 3 | Receive bit index |
| ch_en | output | NUM_CH | Strap-mode per-channel window |
| ch_bit | output | 3*NUM_CH | Strap-mode per-channel bit index, packed |
| frame_err | output | 1 | Sticky early-sync flag |
| sync_lost | output | 1 | No sync seen for two frame periods |

## Verification
A table of delay pairs is run with both one-clock sync pulses and half-frame square waves over three back-to-back frames. Comparing the two sync shapes shows whether the edge detector really fires only on the rising transition. Pairs that are far apart, including 0/7 and 7/0, show whether each direction takes its own delay field and not the other one. Separate tests then check the following:
- a held-high sync gives a single start;
- a delay rewritten mid-frame changes only the next frame;
- an early sync is flagged and restarts the counters;
- a silent input is reported exactly two frames after the last sync;
- in strap mode, overlapping channel pulses stay separate, and the input of the other mode is ignored.

// File: rtl/pcm_frame_timer_pkg.sv
package pcm_frame_timer_pkg;
  localparam int BITS_PER_SLOT = 8;
  localparam int BIT_W = 3;
  localparam int SHIFT_W = 3;

  function automatic int slot_of(input int pos);
    return pos / BITS_PER_SLOT;
  endfunction

  function automatic int bit_of(input int pos);
    return pos % BITS_PER_SLOT;
  endfunction

  function automatic bit is_early(input int since, input int frame_len);
    return since < (frame_len - 1);
  endfunction
endpackage

// File: rtl/fst_sync_mon.sv
module fst_sync_mon #(
  parameter int FRAME_LEN = 32,
  parameter int LOSS_LEN = 64,
  localparam int SINCE_W = $clog2(LOSS_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt,
  output logic frame_err,
  output logic sync_lost
);
  import pcm_frame_timer_pkg::*;

  logic [SINCE_W-1:0] since_q;
  logic               early;

  assign early     = sync_evt && is_early(int'(since_q), FRAME_LEN);
  assign sync_lost = (since_q == SINCE_W'(LOSS_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q   <= SINCE_W'(LOSS_LEN);
      frame_err <= 1'b0;
    end else begin
      if (sync_evt) begin
        since_q <= '0;
      end else if (!sync_lost) begin
        since_q <= since_q + 1'b1;
      end
      if (early) begin
        frame_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fst_dir_timer.sv
module fst_dir_timer #(
  parameter int FRAME_LEN = 32,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_evt,
  input  logic [2:0]       shift,
  input  logic             lost,
  output logic             run,
  output logic [POS_W-1:0] pos,
  output logic             start_q
);
  logic       arm_q;
  logic [2:0] cnt_q;
  logic       fire;

  assign fire = sync_evt ? (shift == 3'd0) : (arm_q && cnt_q == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= fire;
      if (sync_evt) begin
        arm_q <= (shift != 3'd0);
        cnt_q <= shift;
      end else if (arm_q) begin
        if (cnt_q == 3'd1) arm_q <= 1'b0;
        cnt_q <= cnt_q - 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      pos <= '0;
    end else if (fire) begin
      run <= 1'b1;
      pos <= '0;
    end else if (lost) begin
      run <= 1'b0;
      pos <= '0;
    end else if (run) begin
      pos <= (pos == POS_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/fst_strap_chan.sv
module fst_strap_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_in,
  output logic       act,
  output logic [2:0] bit_idx
);
  logic prev_q;
  logic fall;

  assign fall = prev_q && !fs_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      act     <= 1'b0;
      bit_idx <= '0;
    end else begin
      prev_q <= fs_in;
      if (fall) begin
        act     <= 1'b1;
        bit_idx <= '0;
      end else if (act) begin
        if (bit_idx == 3'd7) act <= 1'b0;
        bit_idx <= bit_idx + 3'd1;
      end
    end
  end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int NUM_CH = 4,
  parameter int NUM_SLOTS = 4,
  parameter int LOSS_FRAMES = 2,
  localparam int FRAME_LEN = NUM_SLOTS * pcm_frame_timer_pkg::BITS_PER_SLOT,
  localparam int POS_W = $clog2(FRAME_LEN),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int LOSS_LEN = LOSS_FRAMES * FRAME_LEN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strap_mode,
  input  logic                fsync,
  input  logic [NUM_CH-1:0]   ch_fsync,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_tx_shift,
  input  logic [2:0]          cfg_rx_shift,
  output logic                tx_frame_start,
  output logic                tx_slot_en,
  output logic [SLOT_W-1:0]   tx_slot,
  output logic [2:0]          tx_bit,
  output logic                rx_frame_start,
  output logic                rx_slot_en,
  output logic [SLOT_W-1:0]   rx_slot,
  output logic [2:0]          rx_bit,
  output logic [NUM_CH-1:0]   ch_en,
  output logic [3*NUM_CH-1:0] ch_bit,
  output logic                frame_err,
  output logic                sync_lost
);
  import pcm_frame_timer_pkg::*;

  logic             fs_prev_q;
  logic             sync_evt;
  logic [2:0]       tx_shift_q;
  logic [2:0]       rx_shift_q;
  logic             dir_run   [2];
  logic [POS_W-1:0] dir_pos   [2];
  logic             dir_start [2];
  logic [2:0]       dir_shift [2];
  logic [NUM_CH-1:0] ch_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q  <= 1'b0;
      tx_shift_q <= '0;
      rx_shift_q <= '0;
    end else begin
      fs_prev_q <= fsync;
      if (cfg_we) begin
        tx_shift_q <= cfg_tx_shift;
        rx_shift_q <= cfg_rx_shift;
      end
    end
  end

  assign sync_evt = !strap_mode && fsync && !fs_prev_q;

  fst_sync_mon #(.FRAME_LEN(FRAME_LEN), .LOSS_LEN(LOSS_LEN)) u_mon (
    .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt),
    .frame_err(frame_err), .sync_lost(sync_lost)
  );

  assign dir_shift[0] = tx_shift_q;
  assign dir_shift[1] = rx_shift_q;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    fst_dir_timer #(.FRAME_LEN(FRAME_LEN)) u_dir (
      .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt),
      .shift(dir_shift[d]), .lost(sync_lost),
      .run(dir_run[d]), .pos(dir_pos[d]), .start_q(dir_start[d])
    );
  end

  assign tx_slot_en     = dir_run[0] && !sync_lost && !strap_mode;
  assign rx_slot_en     = dir_run[1] && !sync_lost && !strap_mode;
  assign tx_frame_start = dir_start[0] && !strap_mode;
  assign rx_frame_start = dir_start[1] && !strap_mode;
  assign tx_slot        = SLOT_W'(slot_of(int'(dir_pos[0])));
  assign rx_slot        = SLOT_W'(slot_of(int'(dir_pos[1])));
  assign tx_bit         = BIT_W'(bit_of(int'(dir_pos[0])));
  assign rx_bit         = BIT_W'(bit_of(int'(dir_pos[1])));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fst_strap_chan u_ch (
      .clk(clk), .rst_n(rst_n), .fs_in(ch_fsync[c]),
      .act(ch_act[c]), .bit_idx(ch_bit[3*c +: 3])
    );
  end

  assign ch_en = ch_act & {NUM_CH{strap_mode}};
endmodule

// File: rtl/pcm_frame_timer_chk.sv
module pcm_frame_timer_chk #(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_mode,
  input logic              sync_evt,
  input logic              tx_frame_start,
  input logic              tx_slot_en,
  input logic [SLOT_W-1:0] tx_slot,
  input logic [2:0]        tx_bit,
  input logic              rx_frame_start,
  input logic              rx_slot_en,
  input logic [SLOT_W-1:0] rx_slot,
  input logic [2:0]        rx_bit,
  input logic [NUM_CH-1:0] ch_en,
  input logic              frame_err,
  input logic              sync_lost
);
  // R3
  tx_start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_start |-> (tx_slot_en && tx_slot == '0 && tx_bit == 3'd0));

  // R4
  rx_start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_start |-> (rx_slot_en && rx_slot == '0 && rx_bit == 3'd0));

  // R5
  tx_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slot_en && $past(tx_slot_en) && !tx_frame_start) |-> (tx_bit == 3'($past(tx_bit) + 3'd1)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R8
  lost_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!tx_slot_en && !rx_slot_en));

  // R8
  sync_clears_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !sync_lost);

  // R10
  reg_mode_no_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_mode |-> (ch_en == '0));

  // R10
  strap_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_mode |-> (!tx_slot_en && !rx_slot_en && !sync_evt));
endmodule

bind pcm_frame_timer pcm_frame_timer_chk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .sync_evt(sync_evt),
  .tx_frame_start(tx_frame_start), .tx_slot_en(tx_slot_en), .tx_slot(tx_slot), .tx_bit(tx_bit),
  .rx_frame_start(rx_frame_start), .rx_slot_en(rx_slot_en), .rx_slot(rx_slot), .rx_bit(rx_bit),
  .ch_en(ch_en), .frame_err(frame_err), .sync_lost(sync_lost)
);

// File: tb/sim_pcm_frame_timer.sv
module sim_pcm_frame_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int FL = 32;
  localparam int NVEC = 6;
  localparam int VEC_TX[NVEC] = '{0, 7, 0, 3, 5, 1};
  localparam int VEC_RX[NVEC] = '{0, 0, 7, 5, 2, 6};
  localparam int VEC_SQ[NVEC] = '{0, 1, 0, 1, 0, 1};

  logic clk = 0, rst_n = 0, strap_mode = 0, fsync = 0, cfg_we = 0;
  logic [NCH-1:0] ch_fsync = '0;
  logic [2:0] cfg_tx_shift = '0, cfg_rx_shift = '0;
  logic tx_frame_start, tx_slot_en, rx_frame_start, rx_slot_en;
  logic [1:0] tx_slot, rx_slot;
  logic [2:0] tx_bit, rx_bit;
  logic [NCH-1:0] ch_en;
  logic [3*NCH-1:0] ch_bit;
  logic frame_err, sync_lost;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_frame_timer #(.NUM_CH(NCH), .NUM_SLOTS(4), .LOSS_FRAMES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .fsync(fsync), .ch_fsync(ch_fsync),
    .cfg_we(cfg_we), .cfg_tx_shift(cfg_tx_shift), .cfg_rx_shift(cfg_rx_shift),
    .tx_frame_start(tx_frame_start), .tx_slot_en(tx_slot_en), .tx_slot(tx_slot), .tx_bit(tx_bit),
    .rx_frame_start(rx_frame_start), .rx_slot_en(rx_slot_en), .rx_slot(rx_slot), .rx_bit(rx_bit),
    .ch_en(ch_en), .ch_bit(ch_bit), .frame_err(frame_err), .sync_lost(sync_lost));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 0; strap_mode = strap; fsync = 0; ch_fsync = '0; cfg_we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic write_cfg(input int tx, input int rx);
    @(negedge clk);
    cfg_we = 1; cfg_tx_shift = 3'(tx); cfg_rx_shift = 3'(rx);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // expected direction timing, k clocks after the sync edge, delay d
  task automatic chk_dir(input string req, input int k, input int d, input int fs, input int en,
                         input int slot, input int bitv);
    int p;
    p = (k - d - 1) % FL;
    chk({req, " enable"}, en, (k >= d + 1) ? 1 : 0);
    chk({req, " start"}, fs, (k >= d + 1 && p == 0) ? 1 : 0);
    if (k >= d + 1) begin
      chk({req, " slot"}, slot, p / 8);
      chk({req, " bit"}, bitv, p % 8);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    // R1 reset state
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 tx_slot_en", tx_slot_en, 0);
    chk("R1 rx_slot_en", rx_slot_en, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 sync_lost", sync_lost, 1);
    chk("R1 ch_en", int'(ch_en), 0);
    do_reset(0);
    repeat (3) @(negedge clk);
    chk("R1 no sync yet tx_frame_start", tx_frame_start, 0);
    chk("R1 no sync yet sync_lost", sync_lost, 1);

    // table walk: R2 R3 R4 R5 (and R10 ch_fsync ignored)
    for (int v = 0; v < NVEC; v++) begin
      do_reset(0);
      write_cfg(VEC_TX[v], VEC_RX[v]);
      for (int c = 0; c <= 96; c++) begin
        @(negedge clk);
        if (c >= 1) begin
          chk_dir("R3 tx", c, VEC_TX[v], tx_frame_start, tx_slot_en, tx_slot, tx_bit);
          chk_dir("R4 rx", c, VEC_RX[v], rx_frame_start, rx_slot_en, rx_slot, rx_bit);
          chk("R10 ch_en in register mode", int'(ch_en), 0);
        end
        fsync = (VEC_SQ[v] != 0) ? ((c % FL) < 16) : ((c % FL) == 0);
        ch_fsync = (c == 5) ? '1 : '0;
      end
      chk("R7 no error at exact period", frame_err, 0);
      chk("R8 not lost while syncing", sync_lost, 0);
    end

    // R2 held-high sync gives only one start
    do_reset(0);
    write_cfg(1, 1);
    cnt = 0;
    for (int c = 0; c <= 40; c++) begin
      @(negedge clk);
      if (c >= 1) cnt += tx_frame_start;
      fsync = 1;
    end
    chk("R2 held sync single start", cnt, 1);

    // R6 mid-frame rewrite takes effect at next sync
    do_reset(0);
    write_cfg(2, 0);
    for (int c = 0; c <= 40; c++) begin
      @(negedge clk);
      if (c == 3) chk("R6 first frame old delay", tx_frame_start, 1);
      if (c == 35) chk("R6 old delay not reused", tx_frame_start, 0);
      if (c == 38) chk("R6 new delay applied", tx_frame_start, 1);
      fsync = (c == 0 || c == 32);
      cfg_we = (c == 10);
      cfg_tx_shift = 3'd5;
    end
    cfg_we = 0;

    // R7 early sync
    do_reset(0);
    write_cfg(0, 0);
    for (int c = 0; c <= 20; c++) begin
      @(negedge clk);
      if (c == 12) chk("R7 no error before early sync", frame_err, 0);
      if (c == 13) begin
        chk("R7 error set", frame_err, 1);
        chk("R7 restart start", tx_frame_start, 1);
        chk("R7 restart bit", int'(tx_bit), 0);
        chk("R7 restart slot", int'(tx_slot), 0);
      end
      if (c == 20) chk("R7 error sticky", frame_err, 1);
      fsync = (c == 0 || c == 12);
    end

    // R8 loss of sync
    do_reset(0);
    write_cfg(0, 0);
    for (int c = 0; c <= 70; c++) begin
      @(negedge clk);
      if (c == 64) begin
        chk("R8 not yet lost", sync_lost, 0);
        chk("R8 enabled before loss", tx_slot_en, 1);
      end
      if (c == 65) begin
        chk("R8 lost", sync_lost, 1);
        chk("R8 tx forced low", tx_slot_en, 0);
        chk("R8 rx forced low", rx_slot_en, 0);
      end
      fsync = (c == 0);
    end

    // R9 strap mode channels, R10 fsync ignored
    do_reset(1);
    for (int c = 0; c <= 14; c++) begin
      @(negedge clk);
      if (c >= 1) begin
        int exp_en;
        exp_en = ((c >= 2 && c <= 9) ? 4 : 0) | ((c >= 5 && c <= 12) ? 1 : 0);
        chk("R9 ch_en", int'(ch_en), exp_en);
        if (c >= 2 && c <= 9) chk("R9 ch2 bit", int'(ch_bit[8:6]), c - 2);
        if (c >= 5 && c <= 12) chk("R9 ch0 bit", int'(ch_bit[2:0]), c - 5);
        chk("R10 tx quiet in strap", tx_slot_en, 0);
        chk("R10 rx quiet in strap", rx_slot_en, 0);
      end
      ch_fsync = ((c == 0) ? 4'b0100 : 4'b0000) | ((c == 3) ? 4'b0001 : 4'b0000);
      fsync = (c == 0);
    end

    summary();
    $finish;
  end
endmodule